// File: doc/BRIEF.md
# Local Bus Master Transfer Sequencer

This block is the master-side engine between a processor-side request port and a pipelined local system bus. A request carries an address, a size, a direction and a transfer kind. The kind is a plain single transfer, a block read burst, or an atomic read-then-write pair. The sequencer checks the alignment of each request before it touches the bus. For each accepted request it drives one address-phase cycle. It then frees the bus for one cycle, so the addressed slave can say whether it is busy. After that it runs the data phases, waiting in place for as long as the slave holds its ready line low.

An atomic pair keeps a lock on bus ownership from its first address phase to the end of its write half. No other master can step in between the read and the write. Misaligned or reserved requests never reach the bus. They finish at once with an error flag. Every finished request returns a single done pulse. Each read data phase also streams out its data one cycle after it completes.

Top module: `lbus_xfer_seq`

## Requirements
- R1: `req_ready` is high only while the sequencer is idle. A request is taken on a clock edge where `req_valid` and `req_ready` are both high. While a transfer is in progress, `req_ready` stays low and the request inputs are ignored.
- R2: Every bus transaction has a fixed order. First comes exactly one cycle with `bus_req` high, carrying the address, `bus_size` and `bus_write`. Next comes one release cycle with neither `bus_req` nor `bus_dphase` high. Then `bus_dphase` goes high for the data phase.
- R3: A block request (kind code 1) issues one address phase followed by 2 data beats, or by 4 beats when `req_blk4` is 1. Beat i uses address base + 8*i. `bus_size` shows 3 (doubleword). A block is always a read, whatever `req_write` says.
- R4: An atomic request (kind code 2) first makes a complete read transaction to the request address. It then makes a complete write transaction to the same address with `req_wdata`, with no idle cycle between them. The done data is the value read in the first half.
- R5: Size codes are 0 byte, 1 halfword, 2 word and 3 doubleword. A halfword needs addr[0]=0, a word needs addr[1:0]=00 and a doubleword needs addr[2:0]=000. A byte may use any address. A block needs addr[2:0]=000 whatever its size code. Kind code 3 is reserved. A request that breaks these rules produces `rsp_done` and `rsp_err` one cycle after it is taken, with `rsp_rdata`=0 and no bus activity.
- R6: `bus_lock` is high in every cycle of an atomic pair, from its first `bus_req` cycle through its last data cycle. It is low in the cycle where `rsp_done` is high. It is never high for single or block requests, and never high for rejected requests.
- R7: A data beat completes on a clock edge where `bus_dphase` and `bus_rdy` are both high. While `bus_rdy` is low, the sequencer stays in the data phase and holds `bus_addr`, `bus_write` and `bus_wdata` unchanged.
- R8: `rsp_done` pulses for one cycle, one cycle after the last beat completes, with `rsp_err`=0. `rsp_rdata` then holds the following: for a single read, the read data; for a block, the last beat's data; for an atomic pair, the data of its read half; for a single write, 0.
- R9: Every completed read beat gives one `rsp_beat_valid` pulse in the following cycle, with that beat's `bus_rdata` on `rsp_beat_data`. Write beats give no pulse.
- R10: `bus_write` is high exactly during the address and data cycles of write transactions. In those cycles `bus_wdata` carries the request's `req_wdata`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Sequencer idle and able to take a request |
| req_addr | input | AW | Request byte address |
| req_size | input | 2 | Size code (0 byte, 1 half, 2 word, 3 doubleword) |
| req_kind | input | 2 | Kind code (0 single, 1 block, 2 atomic, 3 reserved) |
| req_write | input | 1 | Write direction for single transfers |
| req_blk4 | input | 1 | Block length select: 0 gives 2 beats, 1 gives 4 beats |
| req_wdata | input | DW | Write data for single writes and atomic write halves |
| bus_req | output | 1 | Address-phase cycle |
| bus_dphase | output | 1 | Data-phase cycle |
| bus_addr | output | AW | Address during address and data phases |
| bus_size | output | 2 | Transfer size code on the bus |
| bus_write | output | 1 | Write direction on the bus |
| bus_wdata | output | DW | Write data during write cycles |
| bus_lock | output | 1 | Bus ownership lock for atomic pairs |
| bus_rdy | input | 1 | Slave ready; a beat completes when high in a data phase |
| bus_rdata | input | DW | Slave read data |
| rsp_done | output | 1 | One-cycle completion pulse |
| rsp_err | output | 1 | Completion with error (misaligned or reserved) |
| rsp_rdata | output | DW | Completion data |
| rsp_beat_valid | output | 1 | One-cycle pulse per completed read beat |
| rsp_beat_data | output | DW | Data of the completed read beat |

## Verification
Counting from the edge that takes the request, the address phase is visible in the first cycle after it, the release cycle in the second, and the first data phase in the third. A beat whose slave stall is d cycles lasts d+1 cycles. `rsp_done` therefore lands 2*H + B*(d+1) + 1 cycles after acceptance for H address phases and B beats, and an error completion lands one cycle after acceptance. The bench drives its slave model with a known stall per transfer and computes this count in a function. It samples every cycle on the falling edge, checks the release cycle and the stall holds as they happen, and compares the cycle in which the done pulse appears against the computed count. Read-beat pulses are expected one cycle after each beat completes, and the bench matches them in order against the data its slave returned.

// File: rtl/lbus_pkg.sv
package lbus_pkg;

  typedef enum logic [1:0] {
    SZ_BYTE  = 2'd0,
    SZ_HALF  = 2'd1,
    SZ_WORD  = 2'd2,
    SZ_DWORD = 2'd3
  } lb_size_e;

  typedef enum logic [1:0] {
    K_SINGLE = 2'd0,
    K_BLOCK  = 2'd1,
    K_ATOMIC = 2'd2,
    K_RSVD   = 2'd3
  } lb_kind_e;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_ADDR = 2'd1,
    ST_GAP  = 2'd2,
    ST_DATA = 2'd3
  } lb_state_e;

endpackage

// File: rtl/lbus_align_chk.sv
module lbus_align_chk
  import lbus_pkg::*;
#(
  parameter int AW = 32
) (
  input  logic [AW-1:0] addr_i,
  input  lb_size_e      size_i,
  input  lb_kind_e      kind_i,
  output logic          ok_o
);

  logic size_ok;

  always_comb begin
    unique case (size_i)
      SZ_BYTE:  size_ok = 1'b1;
      SZ_HALF:  size_ok = (addr_i[0] == 1'b0);
      SZ_WORD:  size_ok = (addr_i[1:0] == 2'b00);
      default:  size_ok = (addr_i[2:0] == 3'b000);
    endcase
  end

  always_comb begin
    unique case (kind_i)
      K_BLOCK: ok_o = (addr_i[2:0] == 3'b000);
      K_RSVD:  ok_o = 1'b0;
      default: ok_o = size_ok;
    endcase
  end

endmodule

// File: rtl/lbus_beat_ctr.sv
module lbus_beat_ctr #(
  parameter int AW         = 32,
  parameter int BEAT_BYTES = 8,
  parameter int CW         = 2
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load_i,
  input  logic [AW-1:0] base_i,
  input  logic [CW-1:0] last_idx_i,
  input  logic          step_i,
  output logic [AW-1:0] addr_o,
  output logic          last_o
);

  localparam logic [AW-1:0] STRIDE = AW'(BEAT_BYTES);

  logic [CW-1:0] left_q;
  logic [AW-1:0] addr_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      left_q <= '0;
      addr_q <= '0;
    end else if (load_i) begin
      left_q <= last_idx_i;
      addr_q <= base_i;
    end else if (step_i && (left_q != '0)) begin
      left_q <= left_q - 1'b1;
      addr_q <= addr_q + STRIDE;
    end
  end

  assign addr_o = addr_q;
  assign last_o = (left_q == '0);

  // R3: a new burst is only loaded once the previous one has run out
  a_r3_load_when_drained: assert property (@(posedge clk) disable iff (rst)
    load_i |-> last_o);

endmodule

// File: rtl/lbus_lock_ctl.sv
module lbus_lock_ctl (
  input  logic clk,
  input  logic rst,
  input  logic set_i,
  input  logic clr_i,
  output logic lock_o
);

  logic lock_q;

  always_ff @(posedge clk) begin
    if (rst)        lock_q <= 1'b0;
    else if (set_i) lock_q <= 1'b1;
    else if (clr_i) lock_q <= 1'b0;
  end

  assign lock_o = lock_q;

  // R6: taking and releasing the lock never coincide
  a_r6_set_clr_apart: assert property (@(posedge clk) disable iff (rst)
    !(set_i && clr_i));

  // R6: a release only happens while the lock is held
  a_r6_clr_only_held: assert property (@(posedge clk) disable iff (rst)
    clr_i |-> lock_o);

endmodule

// File: rtl/lbus_xfer_seq.sv
module lbus_xfer_seq
  import lbus_pkg::*;
#(
  parameter int AW         = 32,
  parameter int DW         = 64,
  parameter int BEAT_BYTES = 8,
  parameter int BLK_SHORT  = 2,
  parameter int BLK_LONG   = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          req_valid,
  output logic          req_ready,
  input  logic [AW-1:0] req_addr,
  input  logic [1:0]    req_size,
  input  logic [1:0]    req_kind,
  input  logic          req_write,
  input  logic          req_blk4,
  input  logic [DW-1:0] req_wdata,
  output logic          bus_req,
  output logic          bus_dphase,
  output logic [AW-1:0] bus_addr,
  output logic [1:0]    bus_size,
  output logic          bus_write,
  output logic [DW-1:0] bus_wdata,
  output logic          bus_lock,
  input  logic          bus_rdy,
  input  logic [DW-1:0] bus_rdata,
  output logic          rsp_done,
  output logic          rsp_err,
  output logic [DW-1:0] rsp_rdata,
  output logic          rsp_beat_valid,
  output logic [DW-1:0] rsp_beat_data
);

  localparam int CW = (BLK_LONG > 1) ? $clog2(BLK_LONG) : 1;
  localparam logic [CW-1:0] IDX_SHORT = CW'(BLK_SHORT - 1);
  localparam logic [CW-1:0] IDX_LONG  = CW'(BLK_LONG - 1);

  lb_state_e st_q;
  lb_size_e  c_size_q;
  lb_kind_e  c_kind_q;
  logic      c_write_q;
  logic      c_half_q;
  logic [DW-1:0] c_wdata_q;
  logic [DW-1:0] c_rdata_q;

  logic          done_q, err_q, bv_q;
  logic [DW-1:0] rdata_q, bd_q;

  lb_size_e rq_size;
  lb_kind_e rq_kind;
  assign rq_size = lb_size_e'(req_size);
  assign rq_kind = lb_kind_e'(req_kind);

  logic align_ok;
  logic acc, start;
  logic beat_fire, bc_last, atomic_turn, fin;
  logic eff_write;
  logic [AW-1:0] bc_addr;
  logic [CW-1:0] load_idx;
  logic lock_set, lock_clr, lock_q;

  lbus_align_chk #(.AW(AW)) u_align (
    .addr_i (req_addr),
    .size_i (rq_size),
    .kind_i (rq_kind),
    .ok_o   (align_ok)
  );

  assign acc   = req_valid && (st_q == ST_IDLE);
  assign start = acc && align_ok;

  assign load_idx = (rq_kind == K_BLOCK) ? (req_blk4 ? IDX_LONG : IDX_SHORT) : '0;

  assign beat_fire   = (st_q == ST_DATA) && bus_rdy;
  assign atomic_turn = beat_fire && bc_last && (c_kind_q == K_ATOMIC) && !c_half_q;
  assign fin         = beat_fire && bc_last && !atomic_turn;

  lbus_beat_ctr #(.AW(AW), .BEAT_BYTES(BEAT_BYTES), .CW(CW)) u_beats (
    .clk        (clk),
    .rst        (rst),
    .load_i     (start),
    .base_i     (req_addr),
    .last_idx_i (load_idx),
    .step_i     (beat_fire),
    .addr_o     (bc_addr),
    .last_o     (bc_last)
  );

  assign lock_set = start && (rq_kind == K_ATOMIC);
  assign lock_clr = fin && (c_kind_q == K_ATOMIC);

  lbus_lock_ctl u_lock (
    .clk    (clk),
    .rst    (rst),
    .set_i  (lock_set),
    .clr_i  (lock_clr),
    .lock_o (lock_q)
  );

  always_comb begin
    unique case (c_kind_q)
      K_SINGLE: eff_write = c_write_q;
      K_ATOMIC: eff_write = c_half_q;
      default:  eff_write = 1'b0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q      <= ST_IDLE;
      c_size_q  <= SZ_BYTE;
      c_kind_q  <= K_SINGLE;
      c_write_q <= 1'b0;
      c_half_q  <= 1'b0;
      c_wdata_q <= '0;
      c_rdata_q <= '0;
      done_q    <= 1'b0;
      err_q     <= 1'b0;
      rdata_q   <= '0;
      bv_q      <= 1'b0;
      bd_q      <= '0;
    end else begin
      done_q <= 1'b0;
      err_q  <= 1'b0;
      bv_q   <= 1'b0;
      unique case (st_q)
        ST_IDLE: begin
          if (acc) begin
            if (align_ok) begin
              st_q      <= ST_ADDR;
              c_size_q  <= rq_size;
              c_kind_q  <= rq_kind;
              c_write_q <= req_write;
              c_half_q  <= 1'b0;
              c_wdata_q <= req_wdata;
              c_rdata_q <= '0;
            end else begin
              done_q  <= 1'b1;
              err_q   <= 1'b1;
              rdata_q <= '0;
            end
          end
        end
        ST_ADDR: st_q <= ST_GAP;
        ST_GAP:  st_q <= ST_DATA;
        default: begin
          if (beat_fire) begin
            if (!eff_write) begin
              bv_q      <= 1'b1;
              bd_q      <= bus_rdata;
              c_rdata_q <= bus_rdata;
            end
            if (atomic_turn) begin
              c_half_q <= 1'b1;
              st_q     <= ST_ADDR;
            end else if (fin) begin
              st_q    <= ST_IDLE;
              done_q  <= 1'b1;
              rdata_q <= eff_write ? c_rdata_q : bus_rdata;
            end
          end
        end
      endcase
    end
  end

  assign req_ready      = (st_q == ST_IDLE);
  assign bus_req        = (st_q == ST_ADDR);
  assign bus_dphase     = (st_q == ST_DATA);
  assign bus_addr       = (st_q != ST_IDLE) ? bc_addr : '0;
  assign bus_size       = (st_q == ST_IDLE) ? 2'd0 :
                          (c_kind_q == K_BLOCK) ? SZ_DWORD : c_size_q;
  assign bus_write      = (st_q != ST_IDLE) && eff_write;
  assign bus_wdata      = bus_write ? c_wdata_q : '0;
  assign bus_lock       = lock_q;
  assign rsp_done       = done_q;
  assign rsp_err        = err_q;
  assign rsp_rdata      = rdata_q;
  assign rsp_beat_valid = bv_q;
  assign rsp_beat_data  = bd_q;

  // R2: the address phase lasts one cycle and is followed by a released cycle
  a_r2_release_after_req: assert property (@(posedge clk) disable iff (rst)
    bus_req |=> (!bus_req && !bus_dphase));

  // R2: the data phase opens right after the release cycle
  a_r2_data_after_gap: assert property (@(posedge clk) disable iff (rst)
    bus_req |=> ##1 bus_dphase);

  // R7: a stalled beat holds its address, direction and data
  a_r7_stall_hold: assert property (@(posedge clk) disable iff (rst)
    (bus_dphase && !bus_rdy) |=>
      (bus_dphase && $stable(bus_addr) && $stable(bus_write) && $stable(bus_wdata)));

  // R5: an error completion comes with no bus activity around it
  a_r5_err_silent: assert property (@(posedge clk) disable iff (rst)
    rsp_err |-> (rsp_done && !bus_req && !bus_dphase && $past(!bus_req && !bus_dphase)));

  // R6: the lock is only ever held for atomic pairs
  a_r6_lock_atomic_only: assert property (@(posedge clk) disable iff (rst)
    bus_lock |-> (c_kind_q == K_ATOMIC));

  // R6: the lock is already released when done is reported
  a_r6_free_at_done: assert property (@(posedge clk) disable iff (rst)
    rsp_done |-> !bus_lock);

  // R1: no bus phase is running while a new request can be taken
  a_r1_ready_quiet: assert property (@(posedge clk) disable iff (rst)
    req_ready |-> (!bus_req && !bus_dphase));

  // R9: read-beat pulses only follow a completed data beat
  a_r9_beat_follows: assert property (@(posedge clk) disable iff (rst)
    rsp_beat_valid |-> $past(bus_dphase && bus_rdy && !bus_write));

endmodule

// File: tb/lbus_xfer_seq_tb.sv
`timescale 1ns/1ps
module lbus_xfer_seq_tb;

  localparam int AW = 32;
  localparam int DW = 64;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          req_valid = 1'b0;
  logic          req_ready;
  logic [AW-1:0] req_addr = '0;
  logic [1:0]    req_size = '0;
  logic [1:0]    req_kind = '0;
  logic          req_write = 1'b0;
  logic          req_blk4 = 1'b0;
  logic [DW-1:0] req_wdata = '0;
  logic          bus_req, bus_dphase, bus_write, bus_lock;
  logic [AW-1:0] bus_addr;
  logic [1:0]    bus_size;
  logic [DW-1:0] bus_wdata;
  logic          bus_rdy;
  logic [DW-1:0] bus_rdata;
  logic          rsp_done, rsp_err, rsp_beat_valid;
  logic [DW-1:0] rsp_rdata, rsp_beat_data;

  int n_tests = 0;
  int n_fail  = 0;
  int sl_delay = 0;
  int sl_cnt   = 0;

  always #2 clk = ~clk;

  function automatic logic [DW-1:0] pat(input logic [AW-1:0] a);
    return {a ^ 32'hC3A5_5A3C, ~a};
  endfunction

  assign bus_rdata = pat(bus_addr);
  assign bus_rdy   = bus_dphase && (sl_cnt >= sl_delay);

  always @(posedge clk) begin
    if (rst || !bus_dphase || bus_rdy) sl_cnt <= 0;
    else sl_cnt <= sl_cnt + 1;
  end

  lbus_xfer_seq u_dut (
    .clk(clk), .rst(rst),
    .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr),
    .req_size(req_size), .req_kind(req_kind), .req_write(req_write),
    .req_blk4(req_blk4), .req_wdata(req_wdata),
    .bus_req(bus_req), .bus_dphase(bus_dphase), .bus_addr(bus_addr),
    .bus_size(bus_size), .bus_write(bus_write), .bus_wdata(bus_wdata),
    .bus_lock(bus_lock), .bus_rdy(bus_rdy), .bus_rdata(bus_rdata),
    .rsp_done(rsp_done), .rsp_err(rsp_err), .rsp_rdata(rsp_rdata),
    .rsp_beat_valid(rsp_beat_valid), .rsp_beat_data(rsp_beat_data)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  // R5 rules, written from the requirement
  function automatic bit exp_ok(input logic [AW-1:0] a, input logic [1:0] sz, input logic [1:0] k);
    if (k == 2'd3) return 1'b0;
    if (k == 2'd1) return a[2:0] == 3'b000;
    case (sz)
      2'd0: return 1'b1;
      2'd1: return a[0] == 1'b0;
      2'd2: return a[1:0] == 2'b00;
      default: return a[2:0] == 3'b000;
    endcase
  endfunction

  function automatic int exp_beats(input logic [1:0] k, input logic b4);
    if (k == 2'd1) return b4 ? 4 : 2;
    if (k == 2'd2) return 2;
    return 1;
  endfunction

  function automatic int exp_lat(input bit ok, input logic [1:0] k, input int beats, input int d);
    int h;
    if (!ok) return 1;
    h = (k == 2'd2) ? 2 : 1;
    return 2 * h + beats * (d + 1) + 1;
  endfunction

  task automatic run_xfer(input logic [AW-1:0] a, input logic [1:0] sz, input logic [1:0] k,
                          input logic w, input logic b4, input logic [DW-1:0] wd, input int d);
    bit ok;
    int beats, lat, n, aph, bt, rd_push, rd_seen;
    int lock_bad, gap_bad, stall_bad, dir_bad, addr_bad, beat_bad, rdy_bad;
    logic prev1, prev2, prev_stall;
    logic [AW-1:0] prev_addr;
    logic [DW-1:0] exp_rd [0:3];
    logic [DW-1:0] exp_done;
    logic exp_w;
    ok = exp_ok(a, sz, k);
    beats = exp_beats(k, b4);
    lat = exp_lat(ok, k, beats, d);
    aph = 0; bt = 0; rd_push = 0; rd_seen = 0;
    lock_bad = 0; gap_bad = 0; stall_bad = 0; dir_bad = 0; addr_bad = 0; beat_bad = 0; rdy_bad = 0;
    prev1 = 1'b0; prev2 = 1'b0; prev_stall = 1'b0; prev_addr = '0;
    for (int i = 0; i < 4; i++) exp_rd[i] = '0;

    @(negedge clk);
    check(req_ready == 1'b1, "R1", "ready when idle", {63'd0, req_ready}, 64'd1);
    sl_delay  = d;
    req_addr  = a; req_size = sz; req_kind = k; req_write = w;
    req_blk4  = b4; req_wdata = wd; req_valid = 1'b1;
    n = 0;
    do begin
      @(negedge clk);
      req_valid = 1'b0;
      req_wdata = ~wd;
      n++;
      if (!rsp_done && req_ready) rdy_bad++;
      if (prev1 && (bus_req || bus_dphase)) gap_bad++;
      if (prev2 && !bus_dphase) gap_bad++;
      if (prev_stall && (!bus_dphase || bus_addr != prev_addr)) stall_bad++;
      if (ok && k == 2'd2) begin
        if ((bus_req || bus_dphase) && !bus_lock) lock_bad++;
      end else if (bus_lock) lock_bad++;
      if (rsp_beat_valid) begin
        if (rd_seen >= rd_push || rsp_beat_data != exp_rd[rd_seen]) beat_bad++;
        rd_seen++;
      end
      if (bus_req) begin
        exp_w = (k == 2'd0) ? w : (k == 2'd2) ? (aph == 1) : 1'b0;
        if (bus_addr != a || bus_size != ((k == 2'd1) ? 2'd3 : sz)) addr_bad++;
        if (bus_write != exp_w) dir_bad++;
        aph++;
      end
      if (bus_dphase && bus_rdy) begin
        exp_w = (k == 2'd0) ? w : (k == 2'd2) ? (bt == 1) : 1'b0;
        if (bus_addr != ((k == 2'd1) ? a + 32'(8 * bt) : a)) addr_bad++;
        if (bus_write != exp_w) dir_bad++;
        if (exp_w && bus_wdata != wd) dir_bad++;
        if (!exp_w && rd_push < 4) begin
          exp_rd[rd_push] = pat(bus_addr);
          rd_push++;
        end
        bt++;
      end
      prev2 = prev1;
      prev1 = bus_req;
      prev_stall = bus_dphase && !bus_rdy;
      prev_addr = bus_addr;
    end while (!rsp_done && n < 400);

    if (!ok) exp_done = '0;
    else if (k == 2'd1) exp_done = pat(a + 32'(8 * (beats - 1)));
    else if (k == 2'd0 && w) exp_done = '0;
    else exp_done = pat(a);

    check(n == lat, "R8", "done latency", 64'(n), 64'(lat));
    check(rsp_err == !ok, "R5", "error flag", {63'd0, rsp_err}, {63'd0, !ok});
    check(rsp_rdata == exp_done, "R8", "done data", rsp_rdata, exp_done);
    check(aph == (ok ? ((k == 2'd2) ? 2 : 1) : 0), "R2", "address phases", 64'(aph), 64'(ok ? ((k == 2'd2) ? 2 : 1) : 0));
    check(bt == (ok ? beats : 0), "R3", "data beats", 64'(bt), 64'(ok ? beats : 0));
    check(addr_bad == 0, "R3", "bus address/size", 64'(addr_bad), 64'd0);
    check(dir_bad == 0, (k == 2'd2) ? "R4" : "R10", "direction/write data", 64'(dir_bad), 64'd0);
    check(gap_bad == 0, "R2", "release cycle", 64'(gap_bad), 64'd0);
    check(stall_bad == 0, "R7", "stall hold", 64'(stall_bad), 64'd0);
    check(lock_bad == 0 && !bus_lock, "R6", "lock", 64'(lock_bad), 64'd0);
    check(beat_bad == 0 && rd_seen == rd_push, "R9", "read beat stream", 64'(rd_seen), 64'(rd_push));
    check(rdy_bad == 0, "R1", "ready low while busy", 64'(rdy_bad), 64'd0);
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    n_tests++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin : stim
    int unsigned seed_dummy;
    seed_dummy = $urandom(32'd7315);
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check(req_ready && !bus_req && !bus_dphase && !bus_lock && !rsp_done, "R1",
          "reset state", {59'd0, req_ready, bus_req, bus_dphase, bus_lock, rsp_done}, 64'h10);

    // directed corner cases
    run_xfer(32'h0000_1003, 2'd0, 2'd0, 1'b0, 1'b0, 64'h0, 0);       // R2 byte read, odd address
    run_xfer(32'h0000_2001, 2'd1, 2'd0, 1'b0, 1'b0, 64'h0, 0);       // R5 misaligned half
    run_xfer(32'h0000_2002, 2'd2, 2'd0, 1'b1, 1'b0, 64'h11, 0);      // R5 misaligned word
    run_xfer(32'h0000_2004, 2'd3, 2'd0, 1'b0, 1'b0, 64'h0, 0);       // R5 misaligned doubleword
    run_xfer(32'h0000_3008, 2'd3, 2'd0, 1'b0, 1'b0, 64'h0, 2);       // R7 stalled read
    run_xfer(32'h0000_4010, 2'd3, 2'd1, 1'b0, 1'b0, 64'h0, 1);       // R3 two-beat block
    run_xfer(32'h0000_5020, 2'd0, 2'd1, 1'b1, 1'b1, 64'h22, 0);      // R3 four-beat block, write ignored
    run_xfer(32'h0000_5024, 2'd0, 2'd1, 1'b0, 1'b1, 64'h0, 0);       // R5 misaligned block
    run_xfer(32'h0000_6040, 2'd2, 2'd2, 1'b0, 1'b0, 64'hDEAD_BEEF_0123_4567, 3); // R4 R6 atomic
    run_xfer(32'h0000_6042, 2'd2, 2'd2, 1'b0, 1'b0, 64'h5, 0);       // R6 misaligned atomic, no lock
    run_xfer(32'h0000_7000, 2'd2, 2'd3, 1'b0, 1'b0, 64'h0, 0);       // R5 reserved kind
    run_xfer(32'h0000_8006, 2'd1, 2'd0, 1'b1, 1'b0, 64'hA5A5_0000_FFFF_1234, 2); // R10 half write

    // constrained random
    for (int t = 0; t < 60; t++) begin
      logic [AW-1:0] a;
      logic [1:0] k;
      int sel;
      sel = int'($urandom % 8);
      k = (sel < 3) ? 2'd0 : (sel < 5) ? 2'd1 : (sel < 7) ? 2'd2 : 2'd3;
      a = ($urandom & 32'h0000_FFF8) | (($urandom % 3 == 0) ? 32'($urandom % 8) : 32'd0);
      run_xfer(a, 2'($urandom % 4), k, 1'($urandom % 2), 1'($urandom % 2),
               {$urandom, $urandom}, int'($urandom % 4));
    end

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule